// File: doc/BRIEF.md
# Power Mode Entry Controller

This controller owns the operating mode of a device: a reset-run mode entered at reset, four general run modes, a safe mode, and three low-power modes (halt, stop and standby). Software moves the device by writing a target mode to a control port twice in a row. The first write carries an unlock key and the second carries the bitwise inverse of that key. Both writes must name the same target. Before a transition starts, the per-mode configuration word of the target is screened. A transition-in-progress bit then stays high until the oscillator, the PLL and the memory report ready for the new mode.

When a run mode enters a low-power mode, the controller remembers which run mode made the request. A wake-up event returns the device to exactly that run mode, and this still holds when the event arrives while entry is under way. A hardware safe request overrides everything, including a device that is sitting in stop mode. Safe mode is left only through a keyed request to one of the four run modes, and only once the safe request has been withdrawn. Malformed unlock sequences raise a one-cycle flag for an illegal mode request. Unusable configurations raise a one-cycle flag for an invalid configuration.

Top module: `pmc_ctrl`

## Requirements
- R1: A request is accepted only from two consecutive writes on `ctl_wr`. `ctl_wdata[19:16]` holds the target mode and `ctl_wdata[15:0]` holds the key: 0x5AF0 in the first write and 0xA50F in the second. Mode codes are: reset-run 0, safe 2, run0..run3 4..7, halt 8, stop 10, standby 13.
- R2: `mtrans` rises in the cycle after the accepting write. It stays high until the cycle after the target mode is entered.
- R3: A transition completes only when `osc_rdy` is high (if the target enables the oscillator), `pll_rdy` is high (if the target enables the PLL) and `mem_rdy` is high (unless the target is a low-power mode).
- R4: `cur_mode` and `gs_sysclk` change only at the completion of a transition. `gs_sysclk` then takes the clock-select field of the target configuration.
- R5: A `wake_evt` during entry into halt, stop or standby, or while in one of them, returns the device to the run mode that issued the low-power request. This includes a wake-up in the cycle right after the second keyed write.
- R6: Configuration word of mode m = `mode_cfg[4m+3:4m]`. Bit 0 enables the oscillator, bit 1 enables the PLL, and bits 3:2 select the clock (0 internal RC, 1 oscillator, 2 PLL, 3 reserved). A word is invalid when: the PLL is on and the oscillator is off; the selected source is disabled; or the select is 3. An accepted request to such a mode pulses `irq_iconf` for one cycle and leaves the mode unchanged with `mtrans` low.
- R7: Any of the following discards the pending request and pulses `irq_imode` for one cycle in the following cycle: a wrong key, an inverted key without a prior first write, or a second write whose mode differs from the first.
- R8: While `safe_req` is high and the device is not in, or heading for, safe mode, a transition to safe mode starts in the next cycle. This includes a device in stop mode with no wake-up.
- R9: A keyed request is illegal, and pulses `irq_imode`, in any of these cases: it names an unused mode code; it arrives while a transition is in progress; the device is in a low-power mode; it targets a low-power mode from a mode other than run0..run3; or it leaves safe mode for anything but run0..run3 or while `safe_req` is high.
- R10: After reset the device is in reset-run mode, `mtrans` is low, `gs_sysclk` is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 20 | Control write data: target mode and key |
| mode_cfg | input | 64 | Configuration words of all 16 mode codes |
| osc_rdy | input | 1 | Oscillator stable |
| pll_rdy | input | 1 | PLL locked |
| mem_rdy | input | 1 | Memory ready for run modes |
| wake_evt | input | 1 | Wake-up or interrupt event |
| safe_req | input | 1 | Hardware safe-mode request (level) |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cur_mode | output | 4 | Current mode code |
| gs_sysclk | output | 2 | Current system clock source |
| mtrans | output | 1 | Transition in progress |
| irq_iconf | output | 1 | Invalid configuration pulse |
| irq_imode | output | 1 | Illegal mode request pulse |

## Verification
The bench issues a wake-up one cycle after the keyed write into stop. A design that records the return mode too late, or lets the entry finish first, would come back to an older run mode or pass visibly through stop.

The bench holds oscillator and memory ready low to catch a controller that reports completion early. It feeds half-formed or mismatched unlock pairs, which a careless sequencer would accept or leave armed. It also raises a safe request in stop mode, where a design that waits for a wake-up would hang.

A seeded random walk over run, low-power and safe targets with random configuration words compares mode, clock select and flags against a bench model. That model follows the legality and validity rules.

// File: rtl/pmc_pkg.sv
// Package: shared types and mode-code helpers for the power mode controller.
// Assumes 4-bit mode codes; codes not listed below are unused.
package pmc_pkg;
    localparam int MODE_W    = 4;
    localparam int NUM_MODES = 1 << MODE_W;
    localparam int CFG_W     = 4;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t M_RST_RUN = 4'd0;
    localparam mode_t M_SAFE    = 4'd2;
    localparam mode_t M_RUN0    = 4'd4;
    localparam mode_t M_RUN3    = 4'd7;
    localparam mode_t M_HALT    = 4'd8;
    localparam mode_t M_STOP    = 4'd10;
    localparam mode_t M_STBY    = 4'd13;

    localparam logic [1:0] CLK_IRC = 2'd0;
    localparam logic [1:0] CLK_OSC = 2'd1;
    localparam logic [1:0] CLK_PLL = 2'd2;

    // Per-mode configuration word, bit 0 = osc_on.
    typedef struct packed {
        logic [1:0] clk_sel;
        logic       pll_on;
        logic       osc_on;
    } cfg_t;

    typedef enum logic {PH_STEADY, PH_MOVE} phase_t;

    function automatic logic is_run(input mode_t m);
        return (m >= M_RUN0) && (m <= M_RUN3);
    endfunction

    function automatic logic is_lp(input mode_t m);
        return (m == M_HALT) || (m == M_STOP) || (m == M_STBY);
    endfunction

    function automatic logic is_known(input mode_t m);
        return (m == M_RST_RUN) || (m == M_SAFE) || is_run(m) || is_lp(m);
    endfunction

    function automatic logic cfg_unusable(input cfg_t c);
        return (c.pll_on && !c.osc_on) || (c.clk_sel == 2'd3) ||
               (c.clk_sel == CLK_PLL && !c.pll_on) ||
               (c.clk_sel == CLK_OSC && !c.osc_on);
    endfunction
endpackage

// File: rtl/pmc_unlock.sv
// Module: keyed double-write sequencer. A first write with the key arms it
// and stores the mode; a following write with the inverted key and the same
// mode yields pair_ok. Any other write yields seq_err and disarms.
// Assumes the write strobe is one cycle per write.
module pmc_unlock
    import pmc_pkg::*;
#(
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5AF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  mode_t            wr_mode,
    input  logic [KEY_W-1:0] wr_key,
    output logic             pair_ok,
    output mode_t            pair_mode,
    output logic             seq_err
);
    localparam logic [KEY_W-1:0] INV_KEY = ~UNLOCK_KEY;

    logic  armed_q;
    mode_t armed_mode_q;
    logic  first_ok;

    // Classify the current write against the armed state.
    always_comb begin
        first_ok  = wr_en && !armed_q && (wr_key == UNLOCK_KEY);
        pair_ok   = wr_en && armed_q && (wr_key == INV_KEY) && (wr_mode == armed_mode_q);
        seq_err   = wr_en && !first_ok && !pair_ok;
        pair_mode = armed_mode_q;
    end

    // Arm on a valid first write, disarm on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q      <= 1'b0;
            armed_mode_q <= M_RST_RUN;
        end else if (wr_en) begin
            armed_q <= first_ok;
            if (first_ok) armed_mode_q <= wr_mode;
        end
    end
endmodule

// File: rtl/pmc_cfg_sel.sv
// Module: unpacks the flat configuration vector into per-mode words and
// selects the word of one mode. Purely combinational.
module pmc_cfg_sel
    import pmc_pkg::*;
#(
    parameter int N = NUM_MODES
) (
    input  logic [N*CFG_W-1:0] cfg_vec,
    input  mode_t              sel,
    output cfg_t               cfg
);
    cfg_t tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign tbl[g] = cfg_t'(cfg_vec[g*CFG_W +: CFG_W]);
    end

    // Pick the word of the selected mode.
    always_comb cfg = tbl[sel];
endmodule

// File: rtl/pmc_legal.sv
// Module: screens an unlocked request for legality against the present mode
// and for a usable target configuration. Purely combinational.
// Assumes req_cfg is the configuration word of pair_mode.
module pmc_legal
    import pmc_pkg::*;
(
    input  logic  pair_ok,
    input  logic  seq_err,
    input  mode_t req_mode,
    input  mode_t cur_mode,
    input  logic  busy,
    input  logic  safe_req,
    input  cfg_t  req_cfg,
    output logic  flag_imode,
    output logic  flag_iconf,
    output logic  accept
);
    logic legal;
    logic bad_cfg;

    // Legality rules and configuration screening.
    always_comb begin
        legal = is_known(req_mode) && !busy && !is_lp(cur_mode)
             && (cur_mode != M_SAFE || (is_run(req_mode) && !safe_req))
             && (!is_lp(req_mode) || is_run(cur_mode));
        bad_cfg    = cfg_unusable(req_cfg);
        flag_imode = seq_err || (pair_ok && !legal);
        flag_iconf = pair_ok && legal && bad_cfg;
        accept     = pair_ok && legal && !bad_cfg;
    end
endmodule

// File: rtl/pmc_seq.sv
// Module: mode transition sequencer. Holds current mode, target mode and the
// run mode that issued a low-power request; applies safe requests, wake-ups,
// resource readiness and accepted requests in that priority.
// Assumes tgt_cfg is the configuration word of tgt_mode.
module pmc_seq
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  mode_t      req_mode,
    input  logic       safe_req,
    input  logic       wake_evt,
    input  cfg_t       tgt_cfg,
    input  logic       osc_rdy,
    input  logic       pll_rdy,
    input  logic       mem_rdy,
    input  logic       flag_imode,
    input  logic       flag_iconf,
    output mode_t      cur_mode,
    output mode_t      tgt_mode,
    output logic       busy,
    output logic [1:0] gs_clk,
    output logic       osc_en,
    output logic       pll_en,
    output logic       irq_imode,
    output logic       irq_iconf
);
    phase_t phase_q;
    mode_t  cur_q, tgt_q, ret_q;
    logic   osc_on_q, pll_on_q;
    logic [1:0] gs_q;
    logic   imode_q, iconf_q;
    logic   ready, safe_hit, lp_ctx, wake_hit;

    // Completion and override conditions for this cycle.
    always_comb begin
        busy     = (phase_q == PH_MOVE);
        ready    = (!tgt_cfg.osc_on || osc_rdy) && (!tgt_cfg.pll_on || pll_rdy)
                && (is_lp(tgt_q) || mem_rdy);
        safe_hit = safe_req && !(busy ? (tgt_q == M_SAFE) : (cur_q == M_SAFE));
        lp_ctx   = busy ? is_lp(tgt_q) : is_lp(cur_q);
        wake_hit = wake_evt && lp_ctx;
    end

    // Mode state update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_STEADY;
            cur_q    <= M_RST_RUN;
            tgt_q    <= M_RST_RUN;
            ret_q    <= M_RUN0;
            gs_q     <= CLK_IRC;
            osc_on_q <= 1'b0;
            pll_on_q <= 1'b0;
            imode_q  <= 1'b0;
            iconf_q  <= 1'b0;
        end else begin
            imode_q <= flag_imode;
            iconf_q <= flag_iconf;
            if (safe_hit) begin
                phase_q <= PH_MOVE;
                tgt_q   <= M_SAFE;
            end else if (wake_hit) begin
                phase_q <= PH_MOVE;
                tgt_q   <= ret_q;
            end else if (busy && ready) begin
                phase_q  <= PH_STEADY;
                cur_q    <= tgt_q;
                gs_q     <= tgt_cfg.clk_sel;
                osc_on_q <= tgt_cfg.osc_on;
                pll_on_q <= tgt_cfg.pll_on;
            end else if (accept) begin
                phase_q <= PH_MOVE;
                tgt_q   <= req_mode;
                if (is_lp(req_mode)) ret_q <= cur_q;
            end
        end
    end

    // Drive resources from the target while moving, else from the held mode.
    always_comb begin
        osc_en    = busy ? tgt_cfg.osc_on : osc_on_q;
        pll_en    = busy ? tgt_cfg.pll_on : pll_on_q;
        cur_mode  = cur_q;
        tgt_mode  = tgt_q;
        gs_clk    = gs_q;
        irq_imode = imode_q;
        irq_iconf = iconf_q;
    end
endmodule

// File: rtl/pmc_ctrl.sv
// Module: top of the power mode entry controller. Wires the unlock
// sequencer, configuration selectors, legality screen and mode sequencer.
// Assumes all inputs are synchronous to clk.
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5AF0,
    localparam int              CTL_W      = KEY_W + MODE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [CTL_W-1:0]           ctl_wdata,
    input  logic [NUM_MODES*CFG_W-1:0] mode_cfg,
    input  logic                       osc_rdy,
    input  logic                       pll_rdy,
    input  logic                       mem_rdy,
    input  logic                       wake_evt,
    input  logic                       safe_req,
    output logic                       osc_en,
    output logic                       pll_en,
    output logic [MODE_W-1:0]          cur_mode,
    output logic [1:0]                 gs_sysclk,
    output logic                       mtrans,
    output logic                       irq_iconf,
    output logic                       irq_imode
);
    logic  pair_ok, seq_err, flag_imode, flag_iconf, accept, busy;
    mode_t pair_mode, cur_m, tgt_m;
    cfg_t  req_cfg, tgt_cfg;

    pmc_unlock #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr),
        .wr_mode(ctl_wdata[KEY_W +: MODE_W]), .wr_key(ctl_wdata[KEY_W-1:0]),
        .pair_ok(pair_ok), .pair_mode(pair_mode), .seq_err(seq_err)
    );

    pmc_cfg_sel #(.N(NUM_MODES)) u_req_cfg (
        .cfg_vec(mode_cfg), .sel(pair_mode), .cfg(req_cfg)
    );

    pmc_cfg_sel #(.N(NUM_MODES)) u_tgt_cfg (
        .cfg_vec(mode_cfg), .sel(tgt_m), .cfg(tgt_cfg)
    );

    pmc_legal u_legal (
        .pair_ok(pair_ok), .seq_err(seq_err), .req_mode(pair_mode),
        .cur_mode(cur_m), .busy(busy), .safe_req(safe_req), .req_cfg(req_cfg),
        .flag_imode(flag_imode), .flag_iconf(flag_iconf), .accept(accept)
    );

    pmc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_mode(pair_mode),
        .safe_req(safe_req), .wake_evt(wake_evt), .tgt_cfg(tgt_cfg),
        .osc_rdy(osc_rdy), .pll_rdy(pll_rdy), .mem_rdy(mem_rdy),
        .flag_imode(flag_imode), .flag_iconf(flag_iconf),
        .cur_mode(cur_m), .tgt_mode(tgt_m), .busy(busy), .gs_clk(gs_sysclk),
        .osc_en(osc_en), .pll_en(pll_en),
        .irq_imode(irq_imode), .irq_iconf(irq_iconf)
    );

    // Export the status of the current mode.
    always_comb begin
        cur_mode = cur_m;
        mtrans   = busy;
    end
endmodule

// File: rtl/pmc_checker.sv
// Module: assertion checker bound to pmc_ctrl. Tracks the run mode that
// entered a low-power mode and checks port-level rules over time.
module pmc_checker
    import pmc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cur_mode,
    input logic [1:0]  gs_sysclk,
    input logic        mtrans,
    input logic        irq_iconf,
    input logic        irq_imode,
    input logic        safe_req,
    input logic        mem_rdy,
    input logic        osc_en,
    input logic        osc_rdy
);
    mode_t prev_mode, lp_origin;

    // Remember the previous mode and the run mode that went low-power.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mode <= M_RST_RUN;
            lp_origin <= M_RST_RUN;
        end else begin
            prev_mode <= cur_mode;
            if (is_lp(cur_mode) && !is_lp(prev_mode)) lp_origin <= prev_mode;
        end
    end

    assert_mode_moves_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode)) |-> ($past(mtrans) && !mtrans));

    assert_clk_stable_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mtrans |=> $stable(gs_sysclk));

    assert_mem_before_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mtrans) && !is_lp(cur_mode)) |-> $past(mem_rdy));

    assert_osc_before_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mtrans) && $past(osc_en)) |-> $past(osc_rdy));

    assert_safe_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req && cur_mode == M_STOP && !mtrans) |=> mtrans);

    assert_wake_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lp(prev_mode) && !is_lp(cur_mode) && cur_mode != M_SAFE) |-> (cur_mode == lp_origin));

    assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_iconf && irq_imode));

    assert_safe_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == M_SAFE && !mtrans && safe_req) |=> (cur_mode == M_SAFE));
endmodule

bind pmc_ctrl pmc_checker u_pmc_chk (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .gs_sysclk(gs_sysclk),
    .mtrans(mtrans), .irq_iconf(irq_iconf), .irq_imode(irq_imode),
    .safe_req(safe_req), .mem_rdy(mem_rdy), .osc_en(osc_en), .osc_rdy(osc_rdy)
);

// File: tb/tb_pmc_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_ctrl;
    localparam logic [3:0] RST_RUN = 4'd0, SAFE = 4'd2, RUN0 = 4'd4, RUN1 = 4'd5,
                           RUN2 = 4'd6, RUN3 = 4'd7, HALT = 4'd8, STOP = 4'd10, STBY = 4'd13;
    localparam logic [15:0] K1 = 16'h5AF0, K2 = 16'hA50F;

    logic        clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0;
    logic [19:0] ctl_wdata = '0;
    logic [63:0] mode_cfg = '0;
    logic        osc_rdy = 1'b1, pll_rdy = 1'b1, mem_rdy = 1'b1, wake_evt = 1'b0, safe_req = 1'b0;
    logic        osc_en, pll_en, mtrans, irq_iconf, irq_imode;
    logic [3:0]  cur_mode;
    logic [1:0]  gs_sysclk;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    pmc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .mode_cfg(mode_cfg),
        .osc_rdy(osc_rdy), .pll_rdy(pll_rdy), .mem_rdy(mem_rdy), .wake_evt(wake_evt),
        .safe_req(safe_req), .osc_en(osc_en), .pll_en(pll_en), .cur_mode(cur_mode),
        .gs_sysclk(gs_sysclk), .mtrans(mtrans), .irq_iconf(irq_iconf), .irq_imode(irq_imode)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] m, input logic [15:0] k);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = {m, k};
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic keyed(input logic [3:0] m);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = {m, K1};
        @(negedge clk); ctl_wdata = {m, K2};
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic set_cfg(input int m, input logic [3:0] c);
        mode_cfg[m*4 +: 4] = c;
    endtask

    function automatic bit m_run(input logic [3:0] m);
        return m >= RUN0 && m <= RUN3;
    endfunction
    function automatic bit m_lp(input logic [3:0] m);
        return m == HALT || m == STOP || m == STBY;
    endfunction
    function automatic bit m_legal(input logic [3:0] cur, input logic [3:0] req);
        bit known = (req == RST_RUN) || (req == SAFE) || m_run(req) || m_lp(req);
        return known && !m_lp(cur) && (cur != SAFE || m_run(req)) && (!m_lp(req) || m_run(cur));
    endfunction
    function automatic bit m_bad(input logic [3:0] c);
        return (c[1] && !c[0]) || c[3:2] == 2'd3 || (c[3:2] == 2'd2 && !c[1]) || (c[3:2] == 2'd1 && !c[0]);
    endfunction

    initial begin
        logic [3:0] em;
        void'($urandom(32'd4711));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 cur_mode", cur_mode, RST_RUN);
        chk("R10 mtrans", mtrans, 0);
        chk("R10 gs_sysclk", gs_sysclk, 0);
        chk("R10 flags", {irq_iconf, irq_imode}, 0);

        // R1 R2 R4: keyed request to RUN1 with PLL clock
        set_cfg(RUN1, 4'b1011);
        keyed(RUN1);
        chk("R2 mtrans after accept", mtrans, 1);
        chk("R4 mode held during move", cur_mode, RST_RUN);
        chk("R4 clk held during move", gs_sysclk, 0);
        step();
        chk("R1 entered RUN1", cur_mode, RUN1);
        chk("R4 clk after RUN1", gs_sysclk, 2);
        chk("R2 mtrans cleared", mtrans, 0);

        // R3: oscillator not ready holds the transition
        set_cfg(RUN3, 4'b0101);
        osc_rdy = 1'b0;
        keyed(RUN3);
        repeat (3) begin
            step();
            chk("R3 hold on osc_rdy mtrans", mtrans, 1);
            chk("R3 hold on osc_rdy mode", cur_mode, RUN1);
        end
        osc_rdy = 1'b1;
        step();
        chk("R3 entered RUN3", cur_mode, RUN3);
        chk("R4 clk after RUN3", gs_sysclk, 1);

        // R3: memory not ready holds a run-mode entry
        mem_rdy = 1'b0;
        keyed(RUN0);
        step(); step();
        chk("R3 hold on mem_rdy", {mtrans, cur_mode}, {1'b1, RUN3});
        mem_rdy = 1'b1;
        step();
        chk("R3 entered RUN0", cur_mode, RUN0);

        // R5: RUN1 -> RUN3 -> STOP -> wake returns to RUN3
        keyed(RUN1); step();
        keyed(RUN3); step();
        keyed(STOP); step();
        chk("R5 in STOP", cur_mode, STOP);
        chk("R4 clk in STOP", gs_sysclk, 0);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R5 wake starts move", mtrans, 1);
        step();
        chk("R5 back to issuing run mode", cur_mode, RUN3);

        // R5: wake one cycle after the second keyed write
        keyed(STOP);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R5 early wake no STOP", cur_mode, RUN3);
        step();
        chk("R5 early wake returns RUN3", cur_mode, RUN3);
        chk("R5 early wake settled", mtrans, 0);

        // R7: malformed sequences
        wr(RUN2, 16'h1234);
        chk("R7 wrong key flag", irq_imode, 1);
        step();
        chk("R7 flag is a pulse", irq_imode, 0);
        wr(RUN2, K2);
        chk("R7 inverted key first", irq_imode, 1);
        wr(RUN2, K1);
        chk("R7 armed no flag", irq_imode, 0);
        wr(RUN1, K2);
        chk("R7 mode mismatch", irq_imode, 1);
        wr(RUN1, K2);
        chk("R7 discarded pair not armed", irq_imode, 1);
        step();
        chk("R7 mode unchanged", {mtrans, cur_mode}, {1'b0, RUN3});

        // R6: PLL without oscillator
        set_cfg(RUN2, 4'b0010);
        keyed(RUN2);
        chk("R6 iconf pulse", irq_iconf, 1);
        chk("R6 no transition", mtrans, 0);
        step();
        chk("R6 mode unchanged", {irq_iconf, cur_mode}, {1'b0, RUN3});

        // R9: unused mode code
        keyed(4'd3);
        chk("R9 unused code flag", irq_imode, 1);
        chk("R9 unused code no move", mtrans, 0);

        // R8: safe request while in STOP
        keyed(STOP); step();
        chk("R8 in STOP", cur_mode, STOP);
        safe_req = 1'b1;
        step();
        chk("R8 safe move started", mtrans, 1);
        step();
        chk("R8 in SAFE", cur_mode, SAFE);

        // R9: safe exit rules
        set_cfg(RUN2, 4'b0101);
        keyed(RUN2);
        chk("R9 exit blocked while safe_req", irq_imode, 1);
        step();
        chk("R9 still SAFE", cur_mode, SAFE);
        safe_req = 1'b0;
        keyed(HALT);
        chk("R9 safe to halt illegal", irq_imode, 1);
        keyed(RUN2); step();
        chk("R9 safe exit to RUN2", cur_mode, RUN2);

        // Random walk against the bench model (R1 R4 R5 R6 R9)
        em = RUN2;
        for (int i = 0; i < 60; i++) begin
            logic [3:0] req, c, prev;
            int pick;
            pick = $urandom % 10;
            case (pick)
                0: req = RST_RUN;
                1: req = RUN0; 2: req = RUN1; 3: req = RUN2; 4: req = RUN3;
                5: req = HALT; 6: req = STOP; 7: req = STBY; 8: req = SAFE;
                default: req = 4'd3;
            endcase
            c = {2'($urandom % 3), 1'($urandom % 2), 1'($urandom % 2)};
            if (($urandom % 2) == 0) c[0] = 1'b1;
            set_cfg(req, c);
            keyed(req);
            if (!m_legal(em, req)) begin
                chk("R9 random illegal flag", irq_imode, 1);
                chk("R9 random illegal no move", mtrans, 0);
            end else if (m_bad(c)) begin
                chk("R6 random iconf", irq_iconf, 1);
                chk("R6 random no move", mtrans, 0);
            end else begin
                chk("R1 random accepted", {irq_iconf, irq_imode, mtrans}, 3'b001);
                step();
                chk("R1 random mode", cur_mode, req);
                chk("R4 random clk", gs_sysclk, c[3:2]);
                prev = em;
                em = req;
                if (m_lp(req)) begin
                    wake_evt = 1'b1; step(); wake_evt = 1'b0; step();
                    chk("R5 random return", cur_mode, prev);
                    chk("R4 random return clk", gs_sysclk, mode_cfg[prev*4+2 +: 2]);
                    em = prev;
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule